// File: doc/BRIEF.md
# Pointer Version Tag Checker

This block guards memory accesses with small version tags. Software stamps every 64-byte line of memory with a 4-bit version, and each pointer carries a version in its top four bits. When tag checking is on for both the page and the running task, the block compares the pointer's version with the version held for the addressed line. It then grants the access or reports a trap. Depending on the access kind and a precise-mode control bit, the trap is precise (it names the faulting address) or deferred (it is logged in a sticky register and the store completes).

The block keeps the line versions in an on-chip tag store indexed by address bits above the line offset. Dedicated tag-set accesses write a new version. Block-initialising stores reset the version of their line to zero. A tag-set access is refused with an access exception when the task has checking disabled or the page is read-only.

Top module: `vtag_checker`

## Requirements
- R1: `req_ready` is always 1. A request accepted at a clock edge (`req_valid`=1) gives `rsp_valid`=1 after that same edge, for exactly one cycle, with `rsp_addr` equal to the request address. An idle cycle gives `rsp_valid`=0.
- R2: The pointer version is `req_addr[63:60]` and the tag store line is `req_addr[13:6]`, so 256 lines of 64 bytes each. Addresses that differ only in bits 5:0 or bits 59:14 share one stored version.
- R3: Loads and stores compare versions only when both `pg_chk_en` and `task_chk_en` are 1. Otherwise they receive class GRANT.
- R4: If either the pointer version or the stored version is 0x0 or 0xF, the versions count as matching.
- R5: A store with a version mismatch gets class DEFERRED (2) when `precise_mode`=0 and class PRECISE (1) when `precise_mode`=1.
- R6: A load with a version mismatch always gets class PRECISE (1), whatever `precise_mode` is.
- R7: A non-faulting load is never compared and always gets class GRANT (0).
- R8: A tag-set access with `task_chk_en`=0 gets class ACCESS (3) with `rsp_ftype`=0xA, and the stored version does not change. This check takes precedence over R9.
- R9: A tag-set access with `pg_writable`=0 gets class ACCESS (3) with `rsp_ftype`=0x5, and the stored version does not change.
- R10: An accepted tag-set access writes `req_tag_wdata` to its line. A block-initialising store writes 0 to its line. Both get class GRANT without any comparison.
- R11: On the first DEFERRED response while `def_valid`=0, `def_valid` becomes 1 and `def_addr` takes the store address. Both then hold until `def_clear` is 1. A `def_clear` in the same cycle as a new deferred store records the new store.
- R12: After reset every stored version is 0, `rsp_valid`=0 and `def_valid`=0. `rsp_ftype` is 0 for every class other than ACCESS.
- Encodings: `req_kind` is 0 load, 1 non-faulting load, 2 store, 3 tag-set, 4 block-init store. `rsp_class` is 0 GRANT, 1 PRECISE, 2 DEFERRED, 3 ACCESS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_addr | input | 64 | Virtual address with version in the top bits |
| req_kind | input | 3 | Access kind |
| req_tag_wdata | input | 4 | Version written by a tag-set access |
| pg_chk_en | input | 1 | Page has version checking on |
| pg_writable | input | 1 | Page is writable |
| task_chk_en | input | 1 | Task-level checking master enable |
| precise_mode | input | 1 | Store mismatches trap precisely |
| rsp_valid | output | 1 | Response present |
| rsp_class | output | 2 | Response class |
| rsp_addr | output | 64 | Address of the request answered |
| rsp_ftype | output | 4 | Fault type for ACCESS responses |
| def_clear | input | 1 | Clears the deferred mismatch log |
| def_valid | output | 1 | A deferred mismatch is logged |
| def_addr | output | 64 | Address of the first logged deferred mismatch |

## Verification
Loads and stores are run against one line under matching, mismatching and reserved versions, in both the pointer and the store. Each enable bit is dropped in turn, which separates a correct compare from gating that ignores one enable. Loads and stores see the same mismatch under both values of `precise_mode`, so a swapped precision rule shows up. Refused tag-set accesses are followed by loads that would only trap if the version stayed unchanged. Aliased and neighbouring addresses expose an index taken from the wrong bits. Two successive deferred stores, with and without a clear, show whether the log keeps the first one.

// File: rtl/vtag_pkg.sv
package vtag_pkg;

    localparam int ADDR_W   = 64;
    localparam int TAG_W    = 4;
    localparam int LINE_LSB = 6;

    typedef enum logic [2:0] {
        K_LOAD    = 3'd0,
        K_NFLOAD  = 3'd1,
        K_STORE   = 3'd2,
        K_TAGSET  = 3'd3,
        K_BLKINIT = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        C_GRANT    = 2'd0,
        C_PRECISE  = 2'd1,
        C_DEFERRED = 2'd2,
        C_ACCESS   = 2'd3
    } class_e;

    localparam logic [3:0] FT_NONE     = 4'h0;
    localparam logic [3:0] FT_DISABLED = 4'hA;
    localparam logic [3:0] FT_READONLY = 4'h5;

    typedef struct packed {
        class_e     cls;
        logic [3:0] ftype;
    } verdict_t;

    function automatic logic tag_is_wild(input logic [TAG_W-1:0] t);
        return (t == '0) || (t == '1);
    endfunction

endpackage

// File: rtl/vtag_store.sv
module vtag_store #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag = mem[rd_idx];
endmodule

// File: rtl/vtag_decide.sv
module vtag_decide
    import vtag_pkg::*;
(
    input  kind_e            kind,
    input  logic [TAG_W-1:0] ptr_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             pg_chk_en,
    input  logic             pg_writable,
    input  logic             task_chk_en,
    input  logic             precise_mode,
    output verdict_t         verdict,
    output logic             wr_en,
    output logic [TAG_W-1:0] wr_tag
);
    logic checking;
    logic mismatch;

    always_comb begin
        checking = pg_chk_en && task_chk_en;
        mismatch = checking && !tag_is_wild(ptr_tag) && !tag_is_wild(line_tag)
                   && (ptr_tag != line_tag);
        verdict  = '{cls: C_GRANT, ftype: FT_NONE};
        wr_en    = 1'b0;
        wr_tag   = '0;
        unique case (kind)
            K_LOAD: begin
                if (mismatch) verdict.cls = C_PRECISE;
            end
            K_STORE: begin
                if (mismatch) verdict.cls = precise_mode ? C_PRECISE : C_DEFERRED;
            end
            K_TAGSET: begin
                if (!task_chk_en) begin
                    verdict = '{cls: C_ACCESS, ftype: FT_DISABLED};
                end else if (!pg_writable) begin
                    verdict = '{cls: C_ACCESS, ftype: FT_READONLY};
                end else begin
                    wr_en  = 1'b1;
                    wr_tag = set_tag;
                end
            end
            K_BLKINIT: begin
                wr_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vtag_deflog.sv
module vtag_deflog #(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              clear,
    output logic              held,
    output logic [ADDR_W-1:0] held_addr
);
    logic room;

    assign room = clear || !held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_addr <= '0;
        end else if (hit && room) begin
            held      <= 1'b1;
            held_addr <= hit_addr;
        end else if (clear) begin
            held      <= 1'b0;
        end
    end
endmodule

// File: rtl/vtag_checker.sv
module vtag_checker
    import vtag_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_kind,
    input  logic [TAG_W-1:0]  req_tag_wdata,
    input  logic              pg_chk_en,
    input  logic              pg_writable,
    input  logic              task_chk_en,
    input  logic              precise_mode,
    output logic              rsp_valid,
    output logic [1:0]        rsp_class,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [3:0]        rsp_ftype,
    input  logic              def_clear,
    output logic              def_valid,
    output logic [ADDR_W-1:0] def_addr
);
    localparam int TAG_LSB = ADDR_W - TAG_W;

    logic [IDX_W-1:0] line_idx;
    logic [TAG_W-1:0] line_tag;
    logic [TAG_W-1:0] ptr_tag;
    verdict_t         verdict;
    logic             dec_wr;
    logic [TAG_W-1:0] dec_wtag;
    logic             accept;
    logic             q_deferred;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign line_idx  = req_addr[LINE_LSB +: IDX_W];
    assign ptr_tag   = req_addr[TAG_LSB +: TAG_W];

    vtag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (line_idx),
        .rd_tag (line_tag),
        .wr_en  (accept && dec_wr),
        .wr_idx (line_idx),
        .wr_tag (dec_wtag)
    );

    vtag_decide u_decide (
        .kind         (kind_e'(req_kind)),
        .ptr_tag      (ptr_tag),
        .line_tag     (line_tag),
        .set_tag      (req_tag_wdata),
        .pg_chk_en    (pg_chk_en),
        .pg_writable  (pg_writable),
        .task_chk_en  (task_chk_en),
        .precise_mode (precise_mode),
        .verdict      (verdict),
        .wr_en        (dec_wr),
        .wr_tag       (dec_wtag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_class <= C_GRANT;
            rsp_addr  <= '0;
            rsp_ftype <= FT_NONE;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_class <= verdict.cls;
                rsp_addr  <= req_addr;
                rsp_ftype <= verdict.ftype;
            end
        end
    end

    assign q_deferred = accept && (verdict.cls == C_DEFERRED);

    vtag_deflog #(.ADDR_W(ADDR_W)) u_deflog (
        .clk       (clk),
        .rst       (rst),
        .hit       (q_deferred),
        .hit_addr  (req_addr),
        .clear     (def_clear),
        .held      (def_valid),
        .held_addr (def_addr)
    );
endmodule

// File: rtl/vtag_checker_sva.sv
module vtag_checker_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_kind,
    input logic        pg_chk_en,
    input logic        task_chk_en,
    input logic        rsp_valid,
    input logic [1:0]  rsp_class,
    input logic [3:0]  rsp_ftype,
    input logic        def_clear,
    input logic        def_valid,
    input logic [63:0] def_addr
);
    a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r1_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r6_load_never_deferred: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 3'd0) |=> (rsp_class != 2'd2));

    a_r7_nfload_granted: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 3'd1) |=> (rsp_class == 2'd0));

    a_r3_gated_granted: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_kind == 3'd0 || req_kind == 3'd2)
         && !(pg_chk_en && task_chk_en)) |=> (rsp_class == 2'd0));

    a_r12_ftype_only_access: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_class != 2'd3) |-> (rsp_ftype == 4'h0));

    a_r11_log_sticky: assert property (@(posedge clk) disable iff (rst)
        (def_valid && !def_clear) |=> (def_valid && $stable(def_addr)));
endmodule

bind vtag_checker vtag_checker_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .pg_chk_en   (pg_chk_en),
    .task_chk_en (task_chk_en),
    .rsp_valid   (rsp_valid),
    .rsp_class   (rsp_class),
    .rsp_ftype   (rsp_ftype),
    .def_clear   (def_clear),
    .def_valid   (def_valid),
    .def_addr    (def_addr)
);

// File: tb/vtag_checker_bench.sv
module vtag_checker_bench;

    typedef struct packed {
        logic [2:0]  kind;
        logic [63:0] addr;
        logic [3:0]  wtag;
        logic        chk;
        logic        wr;
        logic        ten;
        logic        prec;
        logic [1:0]  ecls;
        logic [3:0]  eft;
    } vec_t;

    localparam int NV = 19;
    // kind, addr, wtag, pg_chk, pg_wr, task_en, precise, class, ftype
    localparam vec_t VECS [NV] = '{
        '{3'd0, 64'h5000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R12 R4 stored 0
        '{3'd3, 64'h0000_0000_0000_00C8, 4'hA, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R10 set A
        '{3'd0, 64'hA000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // match
        '{3'd0, 64'h5000_0000_0000_00C4, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'h0}, // R6
        '{3'd0, 64'h5000_0000_0000_00C4, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 4'h0}, // R6 prec=1
        '{3'd2, 64'h5000_0000_0000_00D0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 4'h0}, // R5 precise
        '{3'd1, 64'h5000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R7
        '{3'd0, 64'h5000_0000_0000_00C0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R3 page off
        '{3'd2, 64'h5000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 4'h0}, // R3 task off
        '{3'd0, 64'hF000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R4 ptr F
        '{3'd3, 64'h0000_0000_0000_00C0, 4'h7, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 4'hA}, // R8 over R9
        '{3'd3, 64'h0000_0000_0000_00C0, 4'h7, 1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 4'h5}, // R9
        '{3'd0, 64'h7000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'h0}, // R8 R9 unchanged
        '{3'd4, 64'h7000_0000_0000_00C0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R10 blkinit
        '{3'd0, 64'h7000_0000_0000_00FF, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R10 cleared
        '{3'd3, 64'h0000_0000_0000_017F, 4'h3, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}, // R2 set line5
        '{3'd0, 64'h4000_0000_0000_0140, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'h0}, // R2 same line
        '{3'd0, 64'h4000_0ABC_0000_4140, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 4'h0}, // R2 alias
        '{3'd0, 64'h3000_0000_0000_0180, 4'h2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0}  // R2 neighbour line6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_kind = '0;
    logic [3:0]  req_tag_wdata = '0;
    logic        pg_chk_en = 1'b0;
    logic        pg_writable = 1'b0;
    logic        task_chk_en = 1'b0;
    logic        precise_mode = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_class;
    logic [63:0] rsp_addr;
    logic [3:0]  rsp_ftype;
    logic        def_clear = 1'b0;
    logic        def_valid;
    logic [63:0] def_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vtag_checker u_vtag_checker (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_kind      (req_kind),
        .req_tag_wdata (req_tag_wdata),
        .pg_chk_en     (pg_chk_en),
        .pg_writable   (pg_writable),
        .task_chk_en   (task_chk_en),
        .precise_mode  (precise_mode),
        .rsp_valid     (rsp_valid),
        .rsp_class     (rsp_class),
        .rsp_addr      (rsp_addr),
        .rsp_ftype     (rsp_ftype),
        .def_clear     (def_clear),
        .def_valid     (def_valid),
        .def_addr      (def_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic apply(input vec_t v, input string tag);
        req_valid     = 1'b1;
        req_kind      = v.kind;
        req_addr      = v.addr;
        req_tag_wdata = v.wtag;
        pg_chk_en     = v.chk;
        pg_writable   = v.wr;
        task_chk_en   = v.ten;
        precise_mode  = v.prec;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " R1 rsp_addr"}, rsp_addr, v.addr);
        check({tag, " class"}, 64'(rsp_class), 64'(v.ecls));
        check({tag, " R12 ftype"}, 64'(rsp_ftype), 64'(v.eft));
    endtask

    function automatic vec_t st(input logic [63:0] a, input logic prec, input logic [1:0] c);
        return '{3'd2, a, 4'h0, 1'b1, 1'b1, 1'b1, prec, c, 4'h0};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R12 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R12 def_valid after reset", 64'(def_valid), 64'd0);
        check("R1 req_ready", 64'(req_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], $sformatf("vec%0d", i));
        end

        // idle cycle: no response
        @(negedge clk);
        check("R1 idle no rsp", 64'(rsp_valid), 64'd0);

        // deferred logging: line5 holds 3, pointer 4 mismatches
        check("R11 log empty", 64'(def_valid), 64'd0);
        apply(st(64'h4000_0000_0000_0150, 1'b0, 2'd2), "R5 deferred store");
        check("R11 log set", 64'(def_valid), 64'd1);
        check("R11 log addr", def_addr, 64'h4000_0000_0000_0150);
        apply(st(64'h6000_0000_0000_0160, 1'b0, 2'd2), "R5 second deferred");
        check("R11 keeps first", def_addr, 64'h4000_0000_0000_0150);
        def_clear = 1'b1;
        @(negedge clk);
        def_clear = 1'b0;
        check("R11 cleared", 64'(def_valid), 64'd0);
        // clear together with a new deferred store records it
        def_clear = 1'b1;
        apply(st(64'h6000_0000_0000_0170, 1'b0, 2'd2), "R5 deferred w/ clear");
        def_clear = 1'b0;
        check("R11 set during clear", 64'(def_valid), 64'd1);
        check("R11 addr during clear", def_addr, 64'h6000_0000_0000_0170);
        def_clear = 1'b1;
        apply(st(64'h6000_0000_0000_0174, 1'b0, 2'd2), "R5 deferred replace");
        def_clear = 1'b0;
        check("R11 clear+new", def_addr, 64'h6000_0000_0000_0174);

        // reset clears the store: line5 back to 0
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 def_valid reset", 64'(def_valid), 64'd0);
        apply('{3'd0, 64'h4000_0000_0000_0140, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 4'h0},
              "R12 store reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule